// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller with Two-Step Acknowledge

This block collects interrupt requests from the lines of a shared expansion bus and presents one interrupt signal to the processor. Each request line can be programmed for one of two trigger types. In edge mode, a rising edge latches a request. In level mode, the request follows the line and is active while the line is low, so several cards can drive the same wire. Lines can be masked one by one. Line 0 has the highest priority and the top line has the lowest.

The processor answers an interrupt with two acknowledge pulses. The first pulse picks the winning request and records it in the in-service register. It also freezes the request register until the second pulse. The second pulse returns an 8-bit vector, which is a programmable base in the upper bits with the line number below it. A line that is in service blocks itself and every lower-priority line until software issues an end-of-interrupt (EOI) command. A higher-priority line can still nest on top of it.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A line in edge mode (its trigger bit is 0) sets its request bit on a rising edge. A line held high raises no further request after that request has been serviced.
- R2: A line in level mode (its trigger bit is 1) has its request bit follow the line inverted, one cycle behind it. A low line requests service and a high line does not.
- R3: `int_out` is high exactly when some request bit is set and unmasked (mask bit 0), and no in-service bit is set at that line's priority or above. A mask bit of 1 hides its line.
- R4: Priority is fixed, with line 0 highest. When several lines are eligible together, the lowest-numbered line wins.
- R5: The first acknowledge pulse sets the in-service bit of the winner and clears the winner's request bit if it is an edge line. The request register then holds its value, and line changes are ignored, until the cycle after the second acknowledge pulse.
- R6: The cycle after the second acknowledge pulse, `vec_valid` is high for one cycle. `vec_out` then equals {base[4:0], line[2:0]}.
- R7: If nothing is eligible at the first acknowledge pulse, the vector returns line number 7 and no in-service bit is set.
- R8: An `eoi` pulse clears only the highest-priority set in-service bit. With no bit in service it changes nothing.
- R9: Without an EOI, an in-service line keeps requests of equal and lower priority off `int_out`, while higher-priority requests still raise it.
- R10: A configuration write with `cfg_sel` = 0 loads the mask, 1 loads the trigger bits and 2 loads the base from `cfg_data[4:0]`. After reset the mask is 0, all lines are in edge mode, the base is 0 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Raw request lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 mask, 1 trigger type, 2 vector base |
| cfg_data | input | 8 | Configuration write data |
| ack | input | 1 | Acknowledge pulse; pulses alternate between first and second |
| eoi | input | 1 | End-of-interrupt pulse (nonspecific) |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | One-cycle strobe marking `vec_out` as fresh |
| vec_out | output | 8 | Vector from the last second acknowledge |

## Verification
The bench goes after the following corner cases:

- **Two lines rising in the same cycle.** A resolver with the wrong priority would return the lower-priority number.
- **A request that arrives between the two acknowledge pulses.** If the freeze leaked, the new request would appear early. If the freeze lost the edge, the request would never appear.
- **A level request withdrawn before the first acknowledge.** A controller that commits anyway would set a stray in-service bit and block the lowest line.
- **Nested service.** The bench checks that the EOI clears the inner, higher-priority bit first and leaves the outer line blocked.
- **An EOI with nothing in service.** This must change nothing.
- **A line held high after service.** In edge mode, such a line must not re-request.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned LINES = 8;
  localparam int unsigned IDX_W = $clog2(LINES);

  typedef logic [LINES-1:0] line_vec_t;
  typedef logic [IDX_W-1:0] line_idx_t;
  typedef enum logic {PH_IDLE, PH_HELD} ack_ph_t;

  // index of the lowest set bit (highest priority), 0 when empty
  function automatic line_idx_t first_set(line_vec_t v);
    line_idx_t r;
    r = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (v[i]) r = line_idx_t'(i);
    return r;
  endfunction

  // bits 0..k set: lines at priority k or above
  function automatic line_vec_t upto(line_idx_t k);
    line_vec_t m;
    for (int i = 0; i < LINES; i++)
      m[i] = (i <= int'(k));
    return m;
  endfunction

  function automatic line_vec_t onehot(line_idx_t k);
    return line_vec_t'(1) << k;
  endfunction
endpackage

// File: rtl/prio_irq_req.sv
module prio_irq_req
  import prio_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t irq,
  input  line_vec_t level_mode,
  input  logic      frozen,
  input  line_vec_t taken,
  output line_vec_t irr
);
  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      logic prev_q, req_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          req_q  <= 1'b0;
        end else if (!frozen) begin
          prev_q <= irq[g];
          if (level_mode[g]) req_q <= ~irq[g];
          else               req_q <= (req_q & ~taken[g]) | (irq[g] & ~prev_q);
        end
      end
      assign irr[g] = req_q;
    end
  endgenerate
endmodule

// File: rtl/prio_irq_resolve.sv
module prio_irq_resolve
  import prio_irq_pkg::*;
(
  input  line_vec_t irr,
  input  line_vec_t imr,
  input  line_vec_t isr,
  output logic      int_req,
  output line_idx_t win,
  output line_vec_t eoi_clr
);
  line_vec_t pend;
  logic      blocked;

  always_comb begin
    pend    = irr & ~imr;
    win     = first_set(pend);
    blocked = |(isr & upto(win));
    int_req = (|pend) && !blocked;
    eoi_clr = (|isr) ? onehot(first_set(isr)) : '0;
  end
endmodule

// File: rtl/prio_irq_ack.sv
module prio_irq_ack
  import prio_irq_pkg::*;
#(
  parameter int unsigned VEC_W  = 8,
  localparam int unsigned BASE_W = VEC_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack,
  input  logic              eoi,
  input  logic              int_req,
  input  line_idx_t         win,
  input  line_vec_t         eoi_clr,
  input  logic [BASE_W-1:0] base,
  output line_vec_t         isr,
  output logic              frozen,
  output line_vec_t         taken,
  output logic              grant,
  output logic              spur,
  output logic [VEC_W-1:0]  vec_out,
  output logic              vec_valid
);
  ack_ph_t   phase;
  line_idx_t sel;
  logic      first_ack, second_ack;

  assign first_ack  = ack && (phase == PH_IDLE);
  assign second_ack = ack && (phase == PH_HELD);
  assign grant      = first_ack && int_req;
  assign spur       = first_ack && !int_req;
  assign taken      = grant ? onehot(win) : '0;
  assign frozen     = (phase == PH_HELD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      sel       <= '0;
      isr       <= '0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      isr       <= (isr & ~(eoi ? eoi_clr : '0)) | taken;
      vec_valid <= second_ack;
      if (first_ack) begin
        phase <= PH_HELD;
        sel   <= grant ? win : line_idx_t'(LINES - 1);
      end else if (second_ack) begin
        phase   <= PH_IDLE;
        vec_out <= {base, sel};
      end
    end
  end

  // R5
  grant_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> (isr & $past(taken)) != '0);
  // R6
  vec_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack));
  // R6
  vec_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);
  // R7
  spur_keeps_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spur && !eoi) |=> $stable(isr));
  // R8
  eoi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && isr == '0 && !grant) |=> isr == '0);
  // R8
  eoi_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && isr != '0 && !grant) |=> $countones(isr) == $countones($past(isr)) - 1);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_in,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [LINES-1:0] cfg_data,
  input  logic             ack,
  input  logic             eoi,
  output logic             int_out,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_out
);
  localparam int unsigned BASE_W = VEC_W - IDX_W;

  line_vec_t         imr, level_mode, irr, isr, taken, eoi_clr;
  logic [BASE_W-1:0] base;
  logic              frozen, int_req, grant, spur;
  line_idx_t         win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imr        <= '0;
      level_mode <= '0;
      base       <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0:    imr        <= cfg_data;
        2'd1:    level_mode <= cfg_data;
        2'd2:    base       <= cfg_data[BASE_W-1:0];
        default: ;
      endcase
    end
  end

  prio_irq_req u_req (
    .clk(clk), .rst_n(rst_n), .irq(irq_in), .level_mode(level_mode),
    .frozen(frozen), .taken(taken), .irr(irr)
  );

  prio_irq_resolve u_res (
    .irr(irr), .imr(imr), .isr(isr),
    .int_req(int_req), .win(win), .eoi_clr(eoi_clr)
  );

  prio_irq_ack #(.VEC_W(VEC_W)) u_ack (
    .clk(clk), .rst_n(rst_n), .ack(ack), .eoi(eoi), .int_req(int_req),
    .win(win), .eoi_clr(eoi_clr), .base(base), .isr(isr), .frozen(frozen),
    .taken(taken), .grant(grant), .spur(spur), .vec_out(vec_out),
    .vec_valid(vec_valid)
  );

  assign int_out = int_req;

  // R5
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(irr));
  // R3
  int_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr & ~imr) != '0);
  // R5
  grant_has_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> int_out && !spur);
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_data = '0;
  logic       ack = 1'b0, eoi = 1'b0;
  logic       int_out, vec_valid;
  logic [7:0] vec_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .ack(ack), .eoi(eoi),
    .int_out(int_out), .vec_valid(vec_valid), .vec_out(vec_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit [7:0] m_irr, m_imr, m_isr, m_lvl, m_prev;
  int       m_base, m_sel, m_phase;
  bit       m_vv;
  int       m_vec;

  function automatic bit model_int();
    for (int i = 0; i < 8; i++) begin
      if (m_isr[i]) return 1'b0;
      if (m_irr[i] && !m_imr[i]) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic int model_win();
    for (int i = 0; i < 8; i++)
      if (m_irr[i] && !m_imr[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_irr = 0; m_imr = 0; m_isr = 0; m_lvl = 0; m_prev = 0;
      m_base = 0; m_sel = 0; m_phase = 0; m_vv = 0; m_vec = 0;
    end else begin
      bit [7:0] n_isr;
      int  took;
      bit  was_held;
      took = -1;
      was_held = (m_phase == 1);
      n_isr = m_isr;
      if (eoi) begin
        for (int i = 0; i < 8; i++)
          if (m_isr[i]) begin n_isr[i] = 1'b0; break; end
      end
      m_vv = 0;
      if (ack && m_phase == 0) begin
        m_phase = 1;
        if (model_int()) begin
          took = model_win();
          n_isr[took] = 1'b1;
          m_sel = took;
        end else m_sel = 7;
      end else if (ack) begin
        m_phase = 0;
        m_vv = 1;
        m_vec = m_base * 8 + m_sel;
      end
      if (!was_held) begin
        for (int i = 0; i < 8; i++) begin
          if (m_lvl[i]) m_irr[i] = !irq_in[i];
          else begin
            if (took == i) m_irr[i] = 1'b0;
            if (irq_in[i] && !m_prev[i]) m_irr[i] = 1'b1;
          end
        end
        m_prev = irq_in;
      end
      m_isr = n_isr;
      if (cfg_we) begin
        if (cfg_sel == 0) m_imr = cfg_data;
        else if (cfg_sel == 1) m_lvl = cfg_data;
        else if (cfg_sel == 2) m_base = cfg_data % 32;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (int_out !== model_int()) begin
        n_fail++;
        $display("FAIL R3 int_out: actual %0b expected %0b at %0t", int_out, model_int(), $time);
      end
      n_chk++;
      if (vec_valid !== m_vv) begin
        n_fail++;
        $display("FAIL R6 vec_valid: actual %0b expected %0b at %0t", vec_valid, m_vv, $time);
      end else if (m_vv && vec_out !== m_vec[7:0]) begin
        n_fail++;
        $display("FAIL R6 vec_out: actual %0h expected %0h at %0t", vec_out, m_vec[7:0], $time);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr_cfg(input int sel, input int data);
    @(negedge clk); cfg_we = 1; cfg_sel = 2'(sel); cfg_data = 8'(data);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic edge_line(input int i);
    @(negedge clk); irq_in[i] = 1'b1;
    @(negedge clk); irq_in[i] = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  task automatic pulse_eoi();
    @(negedge clk); eoi = 1;
    @(negedge clk); eoi = 0;
  endtask

  task automatic ack_pair(input string tag, input int exp);
    pulse_ack();
    pulse_ack();
    check({tag, " vec_valid"}, vec_valid, 1);
    check({tag, " vec_out"}, vec_out, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    check("R10 reset int_out", int_out, 0);
    check("R10 reset vec_valid", vec_valid, 0);
    check("R10 reset vec_out", vec_out, 0);
    rst_n = 1;
    tick();
    wr_cfg(2, 8'h12);                 // base -> vectors 0x90 + line

    edge_line(3);
    check("R1 edge sets request", int_out, 1);
    ack_pair("R6 line3", 8'h93);
    check("R5 edge request cleared", int_out, 0);

    edge_line(5);
    check("R9 lower blocked", int_out, 0);
    edge_line(1);
    check("R9 higher nests", int_out, 1);
    ack_pair("R6 line1", 8'h91);
    pulse_eoi();
    check("R8 inner cleared, outer blocks", int_out, 0);
    pulse_eoi();
    check("R8 outer cleared", int_out, 1);
    ack_pair("R6 line5", 8'h95);
    pulse_eoi();
    check("R8 all clear", int_out, 0);
    pulse_eoi();
    check("R8 idle eoi", int_out, 0);

    @(negedge clk); irq_in[6] = 1; irq_in[2] = 1;
    @(negedge clk); irq_in[6] = 0; irq_in[2] = 0;
    ack_pair("R4 tie", 8'h92);
    check("R9 line6 blocked", int_out, 0);
    pulse_eoi();
    ack_pair("R4 next", 8'h96);
    pulse_eoi();

    @(negedge clk); irq_in[4] = 1;
    tick();
    ack_pair("R1 held line", 8'h94);
    pulse_eoi();
    tick();
    check("R1 held high no re-request", int_out, 0);
    irq_in[4] = 0;

    wr_cfg(0, 8'h10);
    edge_line(4);
    check("R3 masked", int_out, 0);
    wr_cfg(0, 8'h00);
    check("R3 unmasked", int_out, 1);
    ack_pair("R10 mask write", 8'h94);
    pulse_eoi();

    @(negedge clk); irq_in[0] = 1;
    tick();
    ack_pair("R1 line0", 8'h90);
    pulse_eoi();
    wr_cfg(1, 8'h01);
    tick();
    check("R2 level idle high", int_out, 0);
    irq_in[0] = 0;
    tick();
    check("R2 level low requests", int_out, 1);
    ack_pair("R2 level vec", 8'h90);
    check("R9 level in service", int_out, 0);
    pulse_eoi();
    check("R2 level still low", int_out, 1);
    irq_in[0] = 1;
    tick();
    check("R2 level released", int_out, 0);

    irq_in[0] = 0;
    tick();
    check("R2 level again", int_out, 1);
    irq_in[0] = 1;
    tick();
    ack_pair("R7 spurious", 8'h97);
    edge_line(7);
    check("R7 no isr left", int_out, 1);
    ack_pair("R7 real line7", 8'h97);
    pulse_eoi();

    edge_line(2);
    pulse_ack();
    @(negedge clk); irq_in[1] = 1;
    tick();
    check("R5 frozen ignores line1", int_out, 0);
    pulse_ack();
    check("R5 vec", vec_out, 8'h92);
    check("R5 still frozen at vec", int_out, 0);
    tick();
    check("R5 edge seen after unfreeze", int_out, 1);
    irq_in[1] = 0;
    ack_pair("R5 line1", 8'h91);
    pulse_eoi();
    pulse_eoi();
    check("R8 drained", int_out, 0);

    repeat (2) tick();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule